// File: doc/BRIEF.md
# Software-Controlled Reset Register Bank

This block holds a parameterised number of 32-bit control words on a simple register bus. The bus has a byte address, write data, a write strobe and registered read data. Each stored bit drives one peripheral reset line, and a bit value of 1 holds that line in reset. The block's own reset clears every word, so all reset lines start released.

A parameter selects one of two update modes. In full-word mode each register carries 32 reset controls, and a write overwrites the whole word. To change one line, software reads the word, edits it and writes it back. In masked mode each register carries 16 reset controls. The upper half of the write data acts as a per-bit enable for the lower half, so one line can be set or released with a single write.

All reset lines leave the block as one flat vector. Synchronising each line to its target clock domain is left to the consumer.

Top module: `softrst_bank`

## Requirements
- R1: While `rst_n` is low, and after it rises until the first write, every bit of `rst_lines` and of `rd_data` is 0.
- R2: Register n answers at byte addresses 4n to 4n+3, because `addr[1:0]` is ignored. Line number id is register id / W, bit id % W, with W = 16 in masked mode and 32 in full-word mode. That line appears on `rst_lines[id]`, and the vector is NUM_REGS*W wide.
- R3: In full-word mode (MASKED=0), a write replaces all 32 bits of the addressed register.
- R4: In masked mode (MASKED=1), a write with bit k+16 = 1 and bit k = 1 sets line k of the addressed register to 1 (reset asserted).
- R5: In masked mode, a write with bit k+16 = 1 and bit k = 0 clears line k of the addressed register.
- R6: In masked mode, any bit k whose enable bit k+16 is 0 keeps its previous value. A write with an all-zero upper half changes nothing.
- R7: `rd_data` shows, one clock after the address is presented, the value the addressed register held before that edge. When a read and a write to the same register fall in the same cycle, the read returns the old value. In masked mode, bits 31:16 of `rd_data` read 0.
- R8: A write to a register index at or beyond NUM_REGS leaves every line unchanged. A read of such an address returns 0.
- R9: A write appears on `rst_lines` right after the clock edge that accepts it. Without a write, `rst_lines` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset of the bank |
| addr | input | ADDR_W | Byte address; bits 1:0 are ignored |
| wr_data | input | 32 | Write data (in masked mode, bits 31:16 are the enable bits) |
| wr_en | input | 1 | Write strobe for the current cycle |
| rd_data | output | 32 | Registered read data for the previous cycle's address |
| rst_lines | output | NUM_REGS*W | Reset outputs, 1 = reset asserted |

## Verification
A read and a write can hit the same register in the same cycle. The bench drives the write strobe and the matching address together, and checks the result one clock later. `rd_data` must carry the value from before the write, and `rst_lines` must already show the new one. This case runs in both modes, with a partial enable mask in masked mode. Out-of-range writes and all-zero masks are checked by comparing the whole reset vector with a model held in the bench.

// File: rtl/softrst_bank.sv
module softrst_bank #(
  parameter int NUM_REGS = 4,
  parameter bit MASKED   = 1'b1,
  parameter int ADDR_W   = 8,
  localparam int W       = MASKED ? 16 : 32,
  localparam int LINES   = NUM_REGS * W,
  localparam int IDX_W   = ADDR_W - 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]      wr_data,
  input  logic             wr_en,
  output logic [31:0]      rd_data,
  output logic [LINES-1:0] rst_lines
);

  logic [W-1:0] regs [NUM_REGS];
  logic [IDX_W-1:0] idx;
  logic hit;
  logic [31:0] rd_word;

  assign idx = addr[ADDR_W-1:2];
  assign hit = 32'(idx) < NUM_REGS;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    wire sel = wr_en && hit && (idx == IDX_W'(g));
    if (MASKED) begin : g_masked
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) regs[g] <= '0;
        else if (sel)
          regs[g] <= (regs[g] & ~wr_data[31:16]) | (wr_data[15:0] & wr_data[31:16]);
    end else begin : g_plain
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) regs[g] <= '0;
        else if (sel) regs[g] <= wr_data[W-1:0];
    end
    assign rst_lines[g*W +: W] = regs[g];
  end

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (hit && idx == IDX_W'(i)) rd_word[W-1:0] = regs[i];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rd_data <= '0;
    else rd_data <= rd_word;

  a_r9_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(rst_lines));
  a_r8_oob_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !hit) |=> $stable(rst_lines));
  a_r8_oob_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> (rd_data == 32'd0));

  if (MASKED) begin : g_mchk
    a_r7_upper_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[31:16] == 16'd0);
    a_r6_empty_mask_no_change: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data[31:16] == 16'd0) |=> $stable(rst_lines));
  end

endmodule

// File: tb/softrst_bank_tb.sv
module softrst_bank_tb;
  logic clk = 0;
  logic rst_n = 0;
  always #5 clk = ~clk;

  logic [7:0]  addr_m = 0, addr_p = 0;
  logic [31:0] wd_m = 0, wd_p = 0, rd_m, rd_p;
  logic        we_m = 0, we_p = 0;
  logic [63:0] lines_m, lines_p;

  softrst_bank #(.NUM_REGS(4), .MASKED(1'b1), .ADDR_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr_m), .wr_data(wd_m), .wr_en(we_m),
    .rd_data(rd_m), .rst_lines(lines_m));
  softrst_bank #(.NUM_REGS(2), .MASKED(1'b0), .ADDR_W(8)) u_dut_plain (
    .clk(clk), .rst_n(rst_n), .addr(addr_p), .wr_data(wd_p), .wr_en(we_p),
    .rd_data(rd_p), .rst_lines(lines_p));

  int compared = 0, mismatched = 0;
  bit done = 0;
  logic [15:0] em [4];
  logic [31:0] ep [2];

  function automatic logic [63:0] vec_m();
    return {em[3], em[2], em[1], em[0]};
  endfunction
  function automatic logic [63:0] vec_p();
    return {ep[1], ep[0]};
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc_m(logic we, logic [7:0] a, logic [31:0] d);
    we_m = we; addr_m = a; wd_m = d;
    if (we && a[7:2] < 4)
      em[a[3:2]] = (em[a[3:2]] & ~d[31:16]) | (d[15:0] & d[31:16]);
    @(negedge clk);
    we_m = 0;
  endtask

  task automatic cyc_p(logic we, logic [7:0] a, logic [31:0] d);
    we_p = we; addr_p = a; wd_p = d;
    if (we && a[7:2] < 2) ep[a[2]] = d;
    @(negedge clk);
    we_p = 0;
  endtask

  task automatic t_reset();
    chk("R1 masked lines", lines_m, 64'd0);
    chk("R1 plain lines", lines_p, 64'd0);
    chk("R1 rdata", {rd_m, rd_p}, 64'd0);
  endtask

  task automatic t_masked_set_clear();
    cyc_m(1, 8'd4, (32'd1 << 21) | (32'd1 << 5));
    chk("R4 R9 set line 21", lines_m, vec_m());
    chk("R2 line id 21 bit", 64'(lines_m[21]), 64'd1);
    cyc_m(1, 8'd0, 32'h00FF_00F3);
    chk("R4 multi set", lines_m, vec_m());
    cyc_m(1, 8'd0, 32'h0003_0001);
    chk("R5 R6 partial clear", lines_m, vec_m());
    chk("R5 expected lines", 64'(lines_m[15:0]), 64'h00F1);
    cyc_m(1, 8'd0, 32'h0000_FFFF);
    chk("R6 empty mask", lines_m, vec_m());
  endtask

  task automatic t_masked_read();
    cyc_m(0, 8'd4, 32'hFFFF_FFFF);
    chk("R7 read reg1", 64'(rd_m), 64'h0020);
    cyc_m(1, 8'd0, 32'hF000_A000);
    chk("R7 collision old value", 64'(rd_m), 64'h00F1);
    chk("R9 collision new lines", lines_m, vec_m());
    cyc_m(0, 8'd0, 32'd0);
    chk("R7 read after write", 64'(rd_m), 64'hA0F1);
  endtask

  task automatic t_masked_addr();
    cyc_m(1, 8'd11, 32'h8000_8000);
    chk("R2 low addr bits ignored", lines_m, vec_m());
    chk("R2 line 47", 64'(lines_m[47]), 64'd1);
    cyc_m(1, 8'd16, 32'hFFFF_FFFF);
    chk("R8 oob write", lines_m, vec_m());
    cyc_m(0, 8'd200, 32'd0);
    chk("R8 oob read", 64'(rd_m), 64'd0);
  endtask

  task automatic t_plain();
    cyc_p(1, 8'd4, 32'hDEAD_BEEF);
    chk("R3 full write reg1", lines_p, vec_p());
    cyc_p(1, 8'd0, 32'h1234_5678);
    cyc_p(1, 8'd0, 32'h8000_0001);
    chk("R3 overwrite reg0", lines_p, vec_p());
    cyc_p(1, 8'd4, 32'h0000_0002);
    chk("R7 plain collision old", 64'(rd_p), 64'hDEAD_BEEF);
    chk("R9 plain new lines", lines_p, vec_p());
    cyc_p(1, 8'd8, 32'hFFFF_FFFF);
    chk("R8 plain oob write", lines_p, vec_p());
    cyc_p(0, 8'd8, 32'd0);
    chk("R8 plain oob read", 64'(rd_p), 64'd0);
  endtask

  task automatic t_rereset();
    rst_n = 0;
    #1;
    chk("R1 reset mid-run masked", lines_m, 64'd0);
    chk("R1 reset mid-run plain", lines_p, 64'd0);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 after release", {rd_m, rd_p}, 64'd0);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) em[i] = '0;
    for (int i = 0; i < 2; i++) ep[i] = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_masked_set_clear();
    t_masked_read();
    t_masked_addr();
    t_plain();
    t_rereset();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule